// File: doc/BRIEF.md
# Hardware Event Interrupt Aggregator

This block gathers single-cycle event pulses from up to 96 peripherals and turns them into a small number of level-sensitive interrupt requests for a CPU. Each event pulse sets a sticky bit in one of three 32-bit status words. The bit stays set until software writes a one to it. Three interrupt lines share these status words. Each line has its own bank of three 32-bit enable masks, one mask per status word. A line stays high for as long as any status bit that its bank enables is set.

Software reaches the block through a simple 32-bit register bus. The bus has separate read and write strobes and an 8-bit byte address, and read data arrives one cycle after the read strobe. For each line there is also a read-only vector word. It reports the lowest-numbered event that is both pending and enabled for that line, so an interrupt handler can find its source with a single read and does not have to scan the words itself.

Top module: `evt_irq_aggregator`

## Requirements
- R1: After reset every status word and every mask word reads zero, every vector word reads zero, and all of `irq_o` is low.
- R2: A one on `evt_i[n]` in a clock cycle sets bit n%32 of status word n/32. Status words sit at byte offsets 0x00, 0x04 and 0x08. The bit stays set with no further pulse.
- R3: Writing a status word clears each bit where the write data holds a one. Bits where the write data holds a zero keep their value.
- R4: If an event pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask bank of line g starts at offset 0x10 + 0x10*g. Inside a bank, the word at +0x0, +0x4 or +0x8 enables status word 0, 1 or 2. Mask words can be written and read back unchanged.
- R6: `irq_o[g]` is high exactly while some status bit and its bank-g mask bit are both one. It falls after the bit is cleared or disabled.
- R7: The mask bank of one line has no effect on the other lines' outputs or vectors.
- R8: The vector word of line g sits at offset 0x40 + 4*g. Bit 31 is set when line g has any pending enabled event. Bits 6:0 then hold the lowest such event number. All other bits read zero, and the whole word reads zero when nothing is pending.
- R9: `bus_rdata` takes the addressed value at the clock edge where `bus_rd` is sampled high. It keeps its value in every other cycle.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to vector words or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 96 | One-cycle event pulses, bit n is event n |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 3 | Level interrupt request, one per mask bank |

## Verification
The bench fires an event in the same cycle as a write-one clear of the same bit. A design that lets the clear win would silently lose that event. It checks the vector word when event 0 is pending and when nothing is pending. A design without a valid flag would return the same word in both cases. It also places pending events in different status words and clears them in turn, so a priority scan that ran from the top, or that ignored the mask, would report the wrong number. Finally, it writes a mask in one bank and watches the other lines, which catches a bank decode that writes the wrong bank or more than one bank.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  // Address map: 16-byte regions, one region per register group
  localparam int unsigned REGION_SHIFT = 4;
  localparam int unsigned STATUS_REGION = 0;
  localparam int unsigned MASK_REGION0 = 1;
  localparam int unsigned VECTOR_REGION = 4;

  typedef struct packed {
    logic       is_stat;
    logic       is_mask;
    logic       is_vec;
    logic [1:0] grp;
    logic [1:0] sel;
  } evt_dec_t;
endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
  import evt_agg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_LINES = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output evt_dec_t          dec
);
  localparam int unsigned HI_W = ADDR_W - REGION_SHIFT;

  logic [HI_W-1:0] region;
  logic [1:0]      slot;
  logic            aligned;

  assign region  = addr[ADDR_W-1:REGION_SHIFT];
  assign slot    = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    dec         = '0;
    dec.sel     = slot;
    dec.is_stat = aligned && (int'(region) == STATUS_REGION) && (int'(slot) < NUM_WORDS);
    dec.is_mask = aligned && (int'(region) >= MASK_REGION0) &&
                  (int'(region) < MASK_REGION0 + NUM_LINES) && (int'(slot) < NUM_WORDS);
    dec.is_vec  = aligned && (int'(region) == VECTOR_REGION) && (int'(slot) < NUM_LINES);
    dec.grp     = 2'(int'(region) - MASK_REGION0);
  end
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned NUM_EVT = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_set,
  input  logic [NUM_EVT-1:0] evt_clr,
  output logic [NUM_EVT-1:0] stat_q
);
  // A new event outranks a clear of the same bit in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~evt_clr) | evt_set;
  end
endmodule

// File: rtl/evt_line_unit.sv
module evt_line_unit #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mask_we,
  input  logic [1:0]                  mask_sel,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [NUM_WORDS*WORD_W-1:0] stat,
  output logic [NUM_WORDS*WORD_W-1:0] mask_flat,
  output logic                        irq,
  output logic [WORD_W-1:0]           vec
);
  localparam int unsigned NUM_EVT = NUM_WORDS * WORD_W;
  localparam int unsigned IDX_W   = $clog2(NUM_EVT);

  logic [NUM_WORDS-1:0][WORD_W-1:0] mask_q;
  logic [NUM_EVT-1:0]               pend;
  logic [IDX_W-1:0]                 low_idx;

  // Scan downward so the lowest set bit is the last to be written
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [NUM_EVT-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (int'(mask_sel) == k) mask_q[k] <= wdata;
      end
    end
  end

  assign mask_flat = mask_q;
  assign pend      = stat & mask_flat;
  assign irq       = |pend;
  assign low_idx   = lowest_idx(pend);

  always_comb begin
    vec              = '0;
    vec[WORD_W-1]    = irq;
    vec[IDX_W-1:0]   = irq ? low_idx : '0;
  end
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evt_agg_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS*WORD_W-1:0] evt_i,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic [NUM_LINES-1:0]        irq_o
);
  localparam int unsigned NUM_EVT = NUM_WORDS * WORD_W;

  evt_dec_t                              dec;
  logic [NUM_EVT-1:0]                    stat_all;
  logic [NUM_EVT-1:0]                    clr_all;
  logic [NUM_LINES-1:0][NUM_EVT-1:0]     mask_all;
  logic [NUM_LINES-1:0][WORD_W-1:0]      vec_all;
  logic [WORD_W-1:0]                     rd_mux;

  evt_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .NUM_LINES(NUM_LINES)
  ) dec_i (
    .addr(bus_addr), .dec(dec)
  );

  // Write-one clear vector, one slice per status word
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_clr
    assign clr_all[k*WORD_W +: WORD_W] =
      (bus_wr && dec.is_stat && (int'(dec.sel) == k)) ? bus_wdata : '0;
  end

  evt_status_bank #(.NUM_EVT(NUM_EVT)) stat_i (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_i), .evt_clr(clr_all), .stat_q(stat_all)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic line_we;
    assign line_we = bus_wr && dec.is_mask && (int'(dec.grp) == g);
    evt_line_unit #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) line_i (
      .clk(clk), .rst_n(rst_n), .mask_we(line_we), .mask_sel(dec.sel),
      .wdata(bus_wdata), .stat(stat_all), .mask_flat(mask_all[g]),
      .irq(irq_o[g]), .vec(vec_all[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (dec.is_stat && int'(dec.sel) == k) rd_mux = stat_all[k*WORD_W +: WORD_W];
    end
    for (int g = 0; g < NUM_LINES; g++) begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (dec.is_mask && int'(dec.grp) == g && int'(dec.sel) == k)
          rd_mux = mask_all[g][k*WORD_W +: WORD_W];
      end
      if (dec.is_vec && int'(dec.sel) == g) rd_mux = vec_all[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/evt_agg_chk.sv
module evt_agg_chk #(
  parameter int unsigned NUM_EVT   = 96,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WORD_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_EVT-1:0]   evt_i,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [WORD_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_EVT-1:0]   stat_q,
  input logic [NUM_EVT-1:0]   clr_vec
);
  localparam int unsigned MAP_END = 'h40 + 4 * NUM_LINES;

  // R1: outputs held low during reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0 && bus_rdata == '0));

  // R2: a pulse lands in the status bank
  assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R3: only write-one bits may drop
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));

  // R4: event beats a same-cycle clear
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & clr_vec)) |=> ((stat_q & $past(evt_i & clr_vec)) == $past(evt_i & clr_vec)));

  // R6: no request without a pending status bit
  assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|stat_q));

  // R8: vector of line 0 read while it requests shows valid
  assert_vector_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h40) && irq_o[0]) |=> bus_rdata[WORD_W-1]);

  // R10: reads past the map return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) >= MAP_END) |=> (bus_rdata == '0));

  // R9: no read strobe, no change of read data
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind evt_irq_aggregator evt_agg_chk #(
  .NUM_EVT(NUM_WORDS * WORD_W), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .stat_q(stat_all), .clr_vec(clr_all)
);

// File: tb/evt_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module evt_irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  evt_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    evt_i[n] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 'h50; a += 4) rd_check("R1 reset read", 8'(a), 32'h0);
    check("R1 reset irq", {29'b0, irq_o}, 32'h0);
  endtask

  task automatic t_status_set;
    pulse(5); pulse(40); pulse(95);
    rd_check("R2 status word0", 8'h00, 32'h1 << 5);
    rd_check("R2 status word1", 8'h04, 32'h1 << 8);
    rd_check("R2 status word2", 8'h08, 32'h1 << 31);
    check("R6 no irq while masked", {29'b0, irq_o}, 32'h0);
    wr(8'h04, 32'h0);
    rd_check("R3 zero write keeps bit", 8'h04, 32'h1 << 8);
  endtask

  task automatic t_mask_rw;
    for (int g = 0; g < 3; g++)
      for (int k = 0; k < 3; k++)
        wr(8'('h10 + 'h10 * g + 4 * k), 32'hA5C3_0000 ^ 32'(g * 16 + k));
    for (int g = 0; g < 3; g++)
      for (int k = 0; k < 3; k++)
        rd_check("R5 mask readback", 8'('h10 + 'h10 * g + 4 * k), 32'hA5C3_0000 ^ 32'(g * 16 + k));
    for (int g = 0; g < 3; g++)
      for (int k = 0; k < 3; k++)
        wr(8'('h10 + 'h10 * g + 4 * k), 32'h0);
    check("R6 irq low after mask clear", {29'b0, irq_o}, 32'h0);
  endtask

  task automatic t_irq_vector;
    wr(8'h28, 32'h1 << 31);
    check("R6 R7 only line1 requests", {29'b0, irq_o}, 32'h2);
    rd_check("R8 vector line1 event95", 8'h44, 32'h8000_005F);
    rd_check("R7 vector line0 idle", 8'h40, 32'h0);
    wr(8'h10, 32'h1 << 5);
    wr(8'h14, 32'h1 << 8);
    check("R6 line0 and line1 request", {29'b0, irq_o}, 32'h3);
    rd_check("R8 vector line0 lowest 5", 8'h40, 32'h8000_0005);
    wr(8'h00, 32'h1 << 5);
    rd_check("R3 write one clears", 8'h00, 32'h0);
    rd_check("R8 vector line0 next 40", 8'h40, 32'h8000_0028);
    wr(8'h14, 32'h0);
    check("R6 masked line falls", {29'b0, irq_o}, 32'h2);
  endtask

  task automatic t_collide;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h1 << 31; evt_i[95] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; evt_i = '0;
    rd_check("R4 event beats clear", 8'h08, 32'h1 << 31);
    wr(8'h08, 32'h1 << 31);
    rd_check("R3 later clear works", 8'h08, 32'h0);
    check("R6 all lines low", {29'b0, irq_o}, 32'h0);
  endtask

  task automatic t_group2;
    wr(8'h30, 32'h1);
    pulse(0);
    check("R6 R7 only line2 requests", {29'b0, irq_o}, 32'h4);
    rd_check("R8 vector line2 event0", 8'h48, 32'h8000_0000);
  endtask

  task automatic t_unmapped;
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_check("R10 vector write ignored", 8'h48, 32'h8000_0000);
    rd_check("R10 read 0x0C", 8'h0C, 32'h0);
    rd_check("R10 read 0x3C", 8'h3C, 32'h0);
    rd_check("R10 read 0x4C", 8'h4C, 32'h0);
    rd_check("R10 read 0xFC", 8'hFC, 32'h0);
    rd_check("R10 misaligned read", 8'h02, 32'h0);
    check("R10 irq unchanged", {29'b0, irq_o}, 32'h4);
  endtask

  task automatic t_read_timing;
    logic [31:0] d;
    rd(8'h04, d);
    check("R9 read value", d, 32'h1 << 8);
    repeat (3) @(negedge clk);
    check("R9 hold without strobe", bus_rdata, 32'h1 << 8);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h48;
    #1;
    check("R9 not before edge", bus_rdata, 32'h1 << 8);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R9 one cycle latency", bus_rdata, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_set();
    t_mask_rw();
    t_irq_vector();
    t_collide();
    t_group2();
    t_unmapped();
    t_read_timing();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=0 cycles left", 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule